// File: doc/BRIEF.md
# Frame Number Capture Register

This block sits beside a streaming pixel pipeline and records a number for each image. When a new image starts, the block takes the first valid pixel of that image, keeps only its low byte, and stores it. That byte carries the image's sequence number, which normally lies between 1 and 99. The stored value does not change until the next image delivers its first pixel. A controller can therefore read it at any point in that window and always get the same result.

An image start pulse arms the capture. The first valid pixel seen on or after the pulse is the one stored. After that single capture the block disarms itself, so later pixels of the same image have no effect. An out-of-range flag reports when the stored number is 0 or greater than 99. The controller reads through a one-cycle registered port: it raises a read request and receives the data and an acknowledge on the next clock edge.

Top module: `frame_tag_latch`

## Requirements
- R1: While reset is active (rst_n low), and on the first edge after it is released, the stored number, rd_data, rd_ack and tag_err are all 0. A stored 0 means no image has been seen yet.
- R2: When sof and pix_valid are high in the same cycle, bits [7:0] of pix_data are stored at that edge. Bits [23:8] are ignored.
- R3: A valid pixel arriving while the block is not armed leaves the stored number unchanged.
- R4: A sof pulse with pix_valid low arms the block. The next valid pixel, in any later cycle, is then captured.
- R5: A read request (rd_en high) in cycle t makes rd_ack high for exactly the cycle after t, and rd_data then shows the stored number. rd_ack is low one cycle after any cycle with rd_en low.
- R6: When a read and a capture fall in the same cycle, the read returns the value stored before that capture. A read in the following cycle returns the new value.
- R7: tag_err is set by a capture whose byte is 0 or greater than 99, and cleared by a capture whose byte is in 1..99. The boundaries 1 and 99 count as in range. tag_err does not change between captures.
- R8: Several sof pulses before any valid pixel still produce one capture, of the first valid pixel after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel qualifier |
| sof | input | 1 | Start-of-image pulse |
| pix_data | input | 24 | Pixel: three 8-bit components, number in [7:0] |
| rd_en | input | 1 | Controller read request |
| rd_data | output | 8 | Registered read result |
| rd_ack | output | 1 | Read result valid, one cycle after rd_en |
| tag_err | output | 1 | Stored number outside 1..99 |

## Verification
The bench uses the default parameters: a 24-bit pixel, an 8-bit number and the range 1 to 99. With these values every range boundary can be reached with a single pixel: 0, 1, 99 and 100 all appear. The stimulus sets the upper pixel bytes to non-zero patterns, so that a capture taking the wrong bits would show up. Further cases cover a capture and a read in the same cycle, a start pulse repeated before any valid pixel, and a reset in the middle of the run.

// File: rtl/frame_tag_latch.sv
module frame_tag_latch #(
  parameter int PIX_W   = 24,
  parameter int TAG_W   = 8,
  parameter int MIN_NUM = 1,
  parameter int MAX_NUM = 99
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             sof,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             rd_en,
  output logic [TAG_W-1:0] rd_data,
  output logic             rd_ack,
  output logic             tag_err
);

  localparam int CMP_W = TAG_W + 1;

  logic             armed_q;
  logic [TAG_W-1:0] tag_q;
  logic             grab;
  logic [TAG_W-1:0] nxt;
  logic             nxt_bad;

  assign grab    = pix_valid && (sof || armed_q);
  assign nxt     = pix_data[TAG_W-1:0];
  assign nxt_bad = (CMP_W'(nxt) < CMP_W'(MIN_NUM)) || (CMP_W'(nxt) > CMP_W'(MAX_NUM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tag_q   <= '0;
      tag_err <= 1'b0;
    end else begin
      if (grab) begin
        armed_q <= 1'b0;
        tag_q   <= nxt;
        tag_err <= nxt_bad;
      end else if (sof) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) rd_data <= tag_q;
    end
  end

  AST_SOF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && pix_valid) |=> (tag_q == $past(pix_data[TAG_W-1:0]))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !armed_q) |=> $stable(tag_q)); // R3
  AST_ARM_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !pix_valid) |=> armed_q); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack); // R5
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_ack); // R5
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && grab) |=> (rd_data == $past(tag_q))); // R6
  AST_ERR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !grab |=> $stable(tag_err)); // R7
  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> (tag_err == ((tag_q < TAG_W'(MIN_NUM)) || (tag_q > TAG_W'(MAX_NUM))))); // R7

endmodule

// File: tb/frame_tag_latch_tb.sv
`timescale 1ns/1ps
module frame_tag_latch_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pix_valid = 0;
  logic        sof = 0;
  logic [23:0] pix_data = '0;
  logic        rd_en = 0;
  logic [7:0]  rd_data;
  logic        rd_ack;
  logic        tag_err;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  frame_tag_latch dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .sof(sof), .pix_data(pix_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_ack(rd_ack), .tag_err(tag_err)
  );

  // row: {sof, valid, pix[23:0], exp_tag[7:0], exp_err}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b1, 24'hABCD05, 8'd5,   1'b0}, // R2 same-cycle capture
    {1'b0, 1'b1, 24'h000033, 8'd5,   1'b0}, // R3
    {1'b1, 1'b0, 24'h0000EE, 8'd5,   1'b0}, // R4 arm only
    {1'b0, 1'b1, 24'h123463, 8'd99,  1'b0}, // R4 R7 upper bound
    {1'b1, 1'b1, 24'h000064, 8'd100, 1'b1}, // R7 above range
    {1'b0, 1'b1, 24'h000001, 8'd100, 1'b1}, // R3
    {1'b1, 1'b1, 24'hFFFF01, 8'd1,   1'b0}, // R7 lower bound clears
    {1'b1, 1'b1, 24'h550000, 8'd0,   1'b1}, // R7 zero
    {1'b1, 1'b0, 24'h000011, 8'd0,   1'b1}, // R8
    {1'b1, 1'b0, 24'h000012, 8'd0,   1'b1}, // R8
    {1'b0, 1'b1, 24'h77002A, 8'd42,  1'b0}, // R8 single capture
    {1'b0, 1'b1, 24'h00002B, 8'd42,  1'b0}  // R8 R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] et, input logic ee);
    @(negedge clk);
    sof = 0; pix_valid = 0; rd_en = 1;
    @(posedge clk); #1;
    chk(req, {24'd0, rd_data}, {24'd0, et});
    chk(req, {31'd0, tag_err}, {31'd0, ee});
    chk("R5", {31'd0, rd_ack}, 32'd1);
    @(negedge clk);
    rd_en = 0;
    @(posedge clk); #1;
    chk("R5", {31'd0, rd_ack}, 32'd0);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1", {24'd0, rd_data}, 32'd0);
    chk("R1", {31'd0, rd_ack}, 32'd0);
    chk("R1", {31'd0, tag_err}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    read_chk("R1", 8'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sof = VEC[i][34]; pix_valid = VEC[i][33]; pix_data = VEC[i][32:9];
      @(posedge clk);
      read_chk($sformatf("R2/R3/R4/R7/R8 row%0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R6: read colliding with a capture returns the old value
    @(negedge clk);
    sof = 1; pix_valid = 1; pix_data = 24'h010107; rd_en = 1;
    @(posedge clk); #1;
    chk("R6 old", {24'd0, rd_data}, 32'd42);
    @(negedge clk);
    sof = 0; pix_valid = 0;
    @(posedge clk); #1;
    chk("R6 new", {24'd0, rd_data}, 32'd7);
    @(negedge clk); rd_en = 0;

    // R1: reset mid-run
    @(negedge clk);
    sof = 1; pix_valid = 1; pix_data = 24'h0000C8;
    @(posedge clk); #1;
    chk("R7 err set", {31'd0, tag_err}, 32'd1);
    @(negedge clk);
    sof = 0; pix_valid = 0; rst_n = 0;
    #1;
    chk("R1 mid", {31'd0, tag_err}, 32'd0);
    @(negedge clk); rst_n = 1;
    read_chk("R1 mid", 8'd0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule